// File: doc/BRIEF.md
# Priority Threshold Interrupt Arbiter

This block is the decision core of a platform interrupt controller. It sits between a set of interrupt gateways, which present one pending bit per source, and a number of interrupt targets such as processor cores. Software sets a 4-bit priority for each source, an enable bit for every source and target pair, and a threshold for each target. Each target has its own arbiter. The arbiter picks the enabled pending source with the highest priority and drives that target's interrupt line while the winner's priority is strictly above the target's threshold.

A target takes the interrupt by reading its claim register. The read returns the winning source ID, where ID = source bit index + 1 and 0 means nothing is eligible. In the same cycle the block sends a one-cycle claim strobe to that source's gateway, and the gateway then drops the pending bit. When the handler is done, it writes the source ID back to the same register. This sends a one-cycle complete strobe, so the gateway may forward the next request. A read-only configuration word reports the build parameters.

Register access uses a simple port: a write is a single cycle with address and data. A read request returns its data one cycle later, qualified by `rd_valid`. The port logic is a two-state machine. PORT_IDLE means no read data is being returned. PORT_RESP means read data is valid this cycle. An accepted read moves the machine to PORT_RESP from either state (IDLE_TO_RESP, RESP_TO_RESP). A cycle without an accepted read returns it to PORT_IDLE (RESP_TO_IDLE), or keeps it there (IDLE_HOLD).

Top module: `prio_thresh_arbiter`

## Requirements
- R1: Reading word address 0x00 returns the configuration word: bits [7:0] hold the source count, bits [15:8] the target count and bits [23:16] the maximum pending count. The upper bits read 0. With the defaults (8, 2, 4) the word is 0x00040208.
- R2: Priority, enable and threshold registers read back what was written.
  - Source s has its priority in bits [4*(s%8)+3 : 4*(s%8)] of word 0x01 + s/8.
  - The enable bit of source s for target t is bit s of word 0x40 + t.
  - The threshold of target t is bits [3:0] of word 0x80 + t.
  - Unused bits read 0.
- R3: `irq_o[t]` is high in the same cycle if, and only if, some source has its pending bit set, its enable bit for target t set, and a priority strictly greater than the threshold of target t. Targets are independent of each other.
- R4: A source with priority 0 never raises an interrupt and is never returned by a claim, even when the threshold is 0.
- R5: A read of word 0xC0 + t returns the ID (source index + 1) of the highest-priority eligible source for target t. On equal priorities the lowest ID wins. The read returns 0 when `irq_o[t]` is low.
- R6: A claim read that returns ID n > 0 sets `claim_o[n-1]` for exactly the one cycle in which `rd_valid` is high. A claim read that returns 0 raises no strobe.
- R7: Writing a value n in 1..NSRC to word 0xC0 + t sets `complete_o[n-1]` for one cycle, starting the cycle after the write. Any other value raises no strobe and changes no register.
- R8: `rd_valid` and the read data appear exactly one cycle after a read request. If `wr_en` and `rd_en` are high in the same cycle, the write is performed and the read is dropped.
- R9: After reset all priorities, enables and thresholds are 0. While pending inputs are low, `irq_o`, `claim_o`, `complete_o` and `rd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NSRC | Pending bits from the gateways |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| irq_o | output | NTGT | Per-target interrupt lines |
| claim_o | output | NSRC | One-cycle claim strobe per source |
| complete_o | output | NSRC | One-cycle complete strobe per source |

## Verification
The assertions are checked on every cycle. They cover:
- the claim and complete strobes are never more than one-hot;
- a claim strobe only appears with returned read data;
- a complete strobe only follows a write;
- read data only follows an accepted read;
- no target is interrupted while nothing is pending.

Only the bench's scenarios can show that arbitration is correct. That covers the strict threshold compare, tie-breaking on the lowest ID, masking by the enable matrix and by priority 0, and the independence of the two targets. It also covers register read-back, the configuration word, and the value filter on completion writes.

// File: rtl/pta_pkg.sv
package pta_pkg;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int PW = 4;

    // address group in addr[7:6]
    localparam logic [1:0] GRP_MISC  = 2'b00;
    localparam logic [1:0] GRP_EN    = 2'b01;
    localparam logic [1:0] GRP_THR   = 2'b10;
    localparam logic [1:0] GRP_CLAIM = 2'b11;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;
endpackage

// File: rtl/pta_regfile.sv
module pta_regfile
    import pta_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int NTGT     = 2,
    parameter int MAX_PEND = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                addr,
    input  logic [DW-1:0]                wdata,
    output logic [NSRC-1:0][PW-1:0]      prio_o,
    output logic [NTGT-1:0][NSRC-1:0]    en_o,
    output logic [NTGT-1:0][PW-1:0]      thr_o,
    output logic [DW-1:0]                rdata_o
);
    localparam logic [7:0] CFG_SRC  = 8'(NSRC);
    localparam logic [7:0] CFG_TGT  = 8'(NTGT);
    localparam logic [7:0] CFG_PEND = 8'(MAX_PEND);

    logic [NSRC-1:0][PW-1:0]   prio_q;
    logic [NTGT-1:0][NSRC-1:0] en_q;
    logic [NTGT-1:0][PW-1:0]   thr_q;

    logic [1:0] grp;
    logic [5:0] idx;
    assign grp = addr[7:6];
    assign idx = addr[5:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (wr_en) begin
            unique case (grp)
                GRP_MISC: begin
                    for (int s = 0; s < NSRC; s++) begin
                        if (idx == 6'(s / 8 + 1))
                            prio_q[s] <= wdata[4*(s%8) +: PW];
                    end
                end
                GRP_EN: begin
                    for (int t = 0; t < NTGT; t++) begin
                        if (idx == 6'(t))
                            en_q[t] <= wdata[NSRC-1:0];
                    end
                end
                GRP_THR: begin
                    for (int t = 0; t < NTGT; t++) begin
                        if (idx == 6'(t))
                            thr_q[t] <= wdata[PW-1:0];
                    end
                end
                GRP_CLAIM: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (grp)
            GRP_MISC: begin
                if (idx == 6'd0)
                    rdata_o = {8'd0, CFG_PEND, CFG_TGT, CFG_SRC};
                for (int s = 0; s < NSRC; s++) begin
                    if (idx == 6'(s / 8 + 1))
                        rdata_o[4*(s%8) +: PW] = prio_q[s];
                end
            end
            GRP_EN: begin
                for (int t = 0; t < NTGT; t++) begin
                    if (idx == 6'(t))
                        rdata_o[NSRC-1:0] = en_q[t];
                end
            end
            GRP_THR: begin
                for (int t = 0; t < NTGT; t++) begin
                    if (idx == 6'(t))
                        rdata_o[PW-1:0] = thr_q[t];
                end
            end
            GRP_CLAIM: ;
        endcase
    end

    assign prio_o = prio_q;
    assign en_o   = en_q;
    assign thr_o  = thr_q;
endmodule

// File: rtl/pta_tgt_arb.sv
module pta_tgt_arb
    import pta_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDW  = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0]          pend_i,
    input  logic [NSRC-1:0]          en_i,
    input  logic [NSRC-1:0][PW-1:0]  prio_i,
    input  logic [PW-1:0]            thr_i,
    output logic                     irq_o,
    output logic [IDW-1:0]           id_o
);
    logic [PW-1:0]  best_prio;
    logic [IDW-1:0] best_id;

    // strict compare keeps the lowest index on ties; start at 0 masks priority 0
    always_comb begin
        best_prio = '0;
        best_id   = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (pend_i[s] && en_i[s] && (prio_i[s] > best_prio)) begin
                best_prio = prio_i[s];
                best_id   = IDW'(s + 1);
            end
        end
    end

    assign irq_o = (best_prio > thr_i);
    assign id_o  = irq_o ? best_id : '0;
endmodule

// File: rtl/pta_port_fsm.sv
module pta_port_fsm
    import pta_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int NTGT = 2,
    parameter int IDW  = $clog2(NSRC + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    input  logic [DW-1:0]              rf_rdata,
    input  logic [NTGT-1:0][IDW-1:0]   ids_i,
    output logic [DW-1:0]              rdata_o,
    output logic                       rd_valid_o,
    output logic [NSRC-1:0]            claim_o,
    output logic [NSRC-1:0]            complete_o
);
    port_state_e state_q, state_d;

    logic           rd_go;
    logic           hit_claim;
    logic [IDW-1:0] sel_id;
    logic [NSRC-1:0] claim_vec;
    logic [NSRC-1:0] done_vec;

    assign rd_go = rd_en && !wr_en;

    always_comb begin
        hit_claim = 1'b0;
        sel_id    = '0;
        if (addr[7:6] == GRP_CLAIM) begin
            for (int t = 0; t < NTGT; t++) begin
                if (addr[5:0] == 6'(t)) begin
                    hit_claim = 1'b1;
                    sel_id    = ids_i[t];
                end
            end
        end
    end

    always_comb begin
        claim_vec = '0;
        done_vec  = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (sel_id == IDW'(s + 1))
                claim_vec[s] = 1'b1;
            if (wdata == DW'(s + 1))
                done_vec[s] = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: state_d = rd_go ? PORT_RESP : PORT_IDLE;
            PORT_RESP: state_d = rd_go ? PORT_RESP : PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PORT_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o    <= '0;
            claim_o    <= '0;
            complete_o <= '0;
        end else begin
            rdata_o    <= '0;
            claim_o    <= '0;
            complete_o <= '0;
            if (rd_go) begin
                if (hit_claim) begin
                    rdata_o <= DW'(sel_id);
                    claim_o <= claim_vec;
                end else begin
                    rdata_o <= rf_rdata;
                end
            end
            if (wr_en && hit_claim)
                complete_o <= done_vec;
        end
    end

    assign rd_valid_o = (state_q == PORT_RESP);
endmodule

// File: rtl/prio_thresh_arbiter.sv
module prio_thresh_arbiter
    import pta_pkg::*;
#(
    parameter int NSRC     = 8,
    parameter int NTGT     = 2,
    parameter int MAX_PEND = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend_i,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             rd_valid,
    output logic [NTGT-1:0]  irq_o,
    output logic [NSRC-1:0]  claim_o,
    output logic [NSRC-1:0]  complete_o
);
    localparam int IDW = $clog2(NSRC + 1);

    logic [NSRC-1:0][PW-1:0]   prio;
    logic [NTGT-1:0][NSRC-1:0] en;
    logic [NTGT-1:0][PW-1:0]   thr;
    logic [DW-1:0]             rf_rdata;
    logic [NTGT-1:0][IDW-1:0]  ids;

    pta_regfile #(.NSRC(NSRC), .NTGT(NTGT), .MAX_PEND(MAX_PEND)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .prio_o  (prio),
        .en_o    (en),
        .thr_o   (thr),
        .rdata_o (rf_rdata)
    );

    for (genvar t = 0; t < NTGT; t++) begin : g_tgt
        pta_tgt_arb #(.NSRC(NSRC), .IDW(IDW)) u_arb (
            .pend_i (pend_i),
            .en_i   (en[t]),
            .prio_i (prio),
            .thr_i  (thr[t]),
            .irq_o  (irq_o[t]),
            .id_o   (ids[t])
        );
    end

    pta_port_fsm #(.NSRC(NSRC), .NTGT(NTGT), .IDW(IDW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rf_rdata   (rf_rdata),
        .ids_i      (ids),
        .rdata_o    (rdata),
        .rd_valid_o (rd_valid),
        .claim_o    (claim_o),
        .complete_o (complete_o)
    );
endmodule

// File: rtl/pta_chk.sv
module pta_chk #(
    parameter int NSRC = 8,
    parameter int NTGT = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] pend_i,
    input logic            wr_en,
    input logic            rd_en,
    input logic            rd_valid,
    input logic [NTGT-1:0] irq_o,
    input logic [NSRC-1:0] claim_o,
    input logic [NSRC-1:0] complete_o
);
    // R6
    claim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_o));

    // R6
    claim_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|claim_o) |-> rd_valid);

    // R7
    complete_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(complete_o));

    // R7
    complete_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|complete_o) |-> $past(wr_en));

    // R8
    resp_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !wr_en));

    // R3
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> (|pend_i));
endmodule

bind prio_thresh_arbiter pta_chk #(.NSRC(NSRC), .NTGT(NTGT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend_i),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .irq_o      (irq_o),
    .claim_o    (claim_o),
    .complete_o (complete_o)
);

// File: tb/sim_prio_thresh_arbiter.sv
`timescale 1ns/1ps
module sim_prio_thresh_arbiter;
    localparam int NSRC = 8;
    localparam int NTGT = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] pend_i = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            rd_valid;
    logic [NTGT-1:0] irq_o;
    logic [NSRC-1:0] claim_o;
    logic [NSRC-1:0] complete_o;

    always #5 clk = ~clk;

    prio_thresh_arbiter #(.NSRC(NSRC), .NTGT(NTGT)) u0 (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .irq_o(irq_o), .claim_o(claim_o), .complete_o(complete_o)
    );

    int n_run = 0;
    int n_fail = 0;

    typedef struct packed {
        logic [7:0]  pend;
        logic [31:0] prio;
        logic [7:0]  en;
        logic [3:0]  thr;
        logic [3:0]  id;
    } vec_t;

    // target 0 arbitration vectors: pending, priority word, enables, threshold, expected ID
    localparam vec_t VECS [10] = '{
        '{8'h01, 32'h0000_0003, 8'hFF, 4'd0, 4'd1},   // R3 single source
        '{8'h06, 32'h0000_0520, 8'hFF, 4'd1, 4'd3},   // R5 higher priority wins
        '{8'h06, 32'h0000_0520, 8'hFF, 4'd5, 4'd0},   // R3 equal to threshold blocks
        '{8'h06, 32'h0000_0520, 8'hFF, 4'd4, 4'd3},   // R3 one above threshold
        '{8'h06, 32'h0000_0520, 8'h02, 4'd1, 4'd2},   // R3 enable masks source 3
        '{8'h0C, 32'h0000_4400, 8'hFF, 4'd0, 4'd3},   // R5 tie goes to lowest ID
        '{8'h80, 32'h0000_0000, 8'hFF, 4'd0, 4'd0},   // R4 priority zero
        '{8'hFF, 32'h1234_5678, 8'hFF, 4'd7, 4'd1},   // R5 full pend
        '{8'hFE, 32'h1234_5678, 8'hFF, 4'd5, 4'd2},   // R5 next best
        '{8'h00, 32'h1234_5678, 8'hFF, 4'd0, 4'd0}    // R3 nothing pending
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d,
                         output logic v, output logic [NSRC-1:0] cl);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; v = rd_valid; cl = claim_o;
    endtask

    function automatic logic [NSRC-1:0] onehot_of(input logic [3:0] id);
        return (id == 0) ? '0 : NSRC'(1) << (id - 1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic v;
        logic [NSRC-1:0] cl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check(irq_o == 0 && claim_o == 0 && complete_o == 0 && rd_valid == 0, "R9",
              {irq_o, claim_o, complete_o, rd_valid}, 0);
        do_rd(8'h01, d, v, cl);
        check(d == 0, "R9 prio reset", d, 0);
        do_rd(8'h80, d, v, cl);
        check(d == 0, "R9 thr reset", d, 0);

        // R1 configuration word
        do_rd(8'h00, d, v, cl);
        check(v && d == 32'h0004_0208, "R1", d, 32'h0004_0208);

        // table walk on target 0
        foreach (VECS[i]) begin
            do_wr(8'h01, VECS[i].prio);
            do_wr(8'h40, {24'd0, VECS[i].en});
            do_wr(8'h80, {28'd0, VECS[i].thr});
            pend_i = VECS[i].pend;
            #1;
            check(irq_o[0] == (VECS[i].id != 0), "R3 irq", {31'd0, irq_o[0]}, {31'd0, VECS[i].id != 0});
            do_rd(8'hC0, d, v, cl);
            check(v && d == {28'd0, VECS[i].id}, "R5 claim id", d, {28'd0, VECS[i].id});
            check(cl == onehot_of(VECS[i].id), "R6 claim strobe", {24'd0, cl}, {24'd0, onehot_of(VECS[i].id)});
            @(negedge clk);
            check(claim_o == 0, "R6 strobe width", {24'd0, claim_o}, 0);
        end
        pend_i = '0;

        // R2 read-back
        do_rd(8'h01, d, v, cl);
        check(d == 32'h1234_5678, "R2 prio", d, 32'h1234_5678);
        do_wr(8'h41, 32'hFFFF_FF10);
        do_rd(8'h41, d, v, cl);
        check(d == 32'h0000_0010, "R2 enable", d, 32'h10);
        do_wr(8'h81, 32'hFFFF_FFF2);
        do_rd(8'h81, d, v, cl);
        check(d == 32'h2, "R2 thr", d, 32'h2);

        // R3 target 1 independent: source 4 prio 3 > thr1 2, not enabled on target 0
        do_wr(8'h40, 32'h0);
        do_wr(8'h01, 32'h0003_0000);
        pend_i = 8'h10;
        #1;
        check(irq_o == 2'b10, "R3 per target", {30'd0, irq_o}, 32'h2);
        do_rd(8'hC1, d, v, cl);
        check(d == 32'd5 && cl == 8'h10, "R6 target1 claim", {d[15:0], 8'd0, cl}, {16'd5, 8'd0, 8'h10});
        pend_i = 8'h00;   // gateway drops pending after the claim
        #1;
        check(irq_o == 2'b00, "R3 cleared", {30'd0, irq_o}, 0);

        // R7 completion strobes
        do_wr(8'hC1, 32'd5);
        check(complete_o == 8'h10, "R7 complete", {24'd0, complete_o}, 32'h10);
        @(negedge clk);
        check(complete_o == 0, "R7 width", {24'd0, complete_o}, 0);
        do_wr(8'hC1, 32'd0);
        check(complete_o == 0, "R7 id zero", {24'd0, complete_o}, 0);
        do_wr(8'hC0, 32'd9);
        check(complete_o == 0, "R7 out of range", {24'd0, complete_o}, 0);
        do_rd(8'h81, d, v, cl);
        check(d == 32'h2, "R7 no reg change", d, 32'h2);

        // R8 write wins over a simultaneous read
        wr_en = 1'b1; rd_en = 1'b1; addr = 8'h80; wdata = 32'd7;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(rd_valid == 1'b0, "R8 read dropped", {31'd0, rd_valid}, 0);
        do_rd(8'h80, d, v, cl);
        check(v && d == 32'd7, "R8 write taken", d, 32'd7);
        @(negedge clk);
        check(rd_valid == 1'b0, "R8 idle", {31'd0, rd_valid}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule